// File: doc/BRIEF.md
# Flag Threshold Register Load and Read-Back Sequencer

This block keeps the two 14-bit thresholds that a dual-clock FIFO's almost-empty and almost-full flag logic compares against. It reuses the FIFO's own data ports for this, so no separate register bus is needed. While the active-low program-select input is held low, an enabled write-clock edge loads a threshold from the low bits of the write data instead of writing a word into the FIFO. An enabled read-clock edge presents a threshold on the read data output instead of popping a word.

Each clock domain holds its own two-state selector, with the states `SEL_EMPTY` and `SEL_FULL`. On every qualifying edge the selector takes the transition `SEL_EMPTY -> SEL_FULL` or `SEL_FULL -> SEL_EMPTY`. On any other edge it stays in its state. The selectors never reset when program-select is released, so a sequence that stops part-way resumes at the register that comes next. The block also gates the FIFO core's write and read strobes, so a register access is never taken as a data transfer. It steers the core's read data or the read-back value onto the output.

Top module: `ofs_seq_top`

## Requirements
- R1: While `rst_n` is low, both thresholds return to `DEF_OFS` (127), and both selectors return to `SEL_EMPTY`. The read-back display flag clears, so `dout` equals `core_q`.
- R2: On a write-clock edge with `prog_sel_n`=0 and `wr_req_n`=0, the threshold picked by the write selector loads. Repeated edges load the empty, full, empty, full thresholds in turn.
- R3: A load takes only `din[13:0]`. Bits 17:14 of `din` have no effect on the stored threshold.
- R4: On a write-clock edge with `wr_req_n`=1, neither threshold changes and the write selector holds, at either level of `prog_sel_n`.
- R5: `core_wr_en` is 1 exactly when `wr_req_n`=0 and `prog_sel_n`=1. A normal write edge changes no threshold.
- R6: `core_rd_en` is 1 exactly when `rd_req_n`=0 and `prog_sel_n`=1.
- R7: On a read-clock edge with `prog_sel_n`=0 and `rd_req_n`=0, the threshold picked by the read selector appears on `dout` after that edge, with bits 17:14 at zero. Repeated edges show the empty, full, empty thresholds in turn, starting from `SEL_EMPTY`.
- R8: The two selectors are independent. Read-back edges do not move the write selector, and load edges do not move the read selector.
- R9: When a sequence stops after one load and program-select goes high, the next load continues at the full threshold.
- R10: A normal read edge (`prog_sel_n`=1, `rd_req_n`=0) returns `dout` to `core_q`. A read-clock edge with `rd_req_n`=1 leaves `dout` unchanged.
- R11: A read-back on the same edge on which its register loads shows the value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| prog_sel_n | input | 1 | Low: enabled edges access thresholds instead of FIFO data |
| wr_req_n | input | 1 | Write enable, active low |
| rd_req_n | input | 1 | Read enable, active low |
| din | input | 18 | Write data port |
| core_q | input | 18 | Read data from the FIFO core's output register |
| core_wr_en | output | 1 | Gated data-write strobe to the FIFO core |
| core_rd_en | output | 1 | Gated data-read strobe to the FIFO core |
| core_din | output | 18 | Write data forwarded to the FIFO core |
| dout | output | 18 | Read data port: core data or a read-back threshold |
| empty_ofs | output | 14 | Almost-empty threshold for the flag logic |
| full_ofs | output | 14 | Almost-full threshold for the flag logic |

## Verification
A threshold load and a read-back of that same threshold can fall on one instant, because the two clock domains are free to align. The bench drives both clocks in phase. It sets up both selectors to point at the empty threshold, then raises load and read-back requests together. The bench judges the result by requiring `dout` to carry the value from before the edge, while `empty_ofs` takes the new value. Both selectors must then move on to the full threshold.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    function automatic ofs_sel_e sel_step(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction
endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
    import ofs_pkg::*;
#(
    parameter int OW      = 14,
    parameter int DEF_OFS = 127
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_sel_n,
    input  logic          req_n,
    input  logic [OW-1:0] wdata,
    output logic          core_en,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    localparam logic [OW-1:0] DEF_VAL = OW'(DEF_OFS);

    ofs_sel_e state_q, state_d;
    logic     hit, ld_empty, ld_full;

    assign hit     = ~req_n & ~prog_sel_n;
    assign core_en = ~req_n &  prog_sel_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        ld_empty = 1'b0;
        ld_full  = 1'b0;
        unique case (state_q)
            SEL_EMPTY: begin
                ld_empty = hit;
                if (hit) state_d = sel_step(state_q);
            end
            SEL_FULL: begin
                ld_full = hit;
                if (hit) state_d = sel_step(state_q);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_ofs <= DEF_VAL;
            full_ofs  <= DEF_VAL;
        end else begin
            if (ld_empty) empty_ofs <= wdata;
            if (ld_full)  full_ofs  <= wdata;
        end
    end
endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
    import ofs_pkg::*;
#(
    parameter int DW = 18,
    parameter int OW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_sel_n,
    input  logic          req_n,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    input  logic [DW-1:0] core_q,
    output logic          core_en,
    output logic [DW-1:0] dout
);
    localparam int PADW = DW - OW;

    ofs_sel_e      state_q, state_d;
    logic          hit, show_q, show_d;
    logic [OW-1:0] rb_q, rb_d;

    assign hit     = ~req_n & ~prog_sel_n;
    assign core_en = ~req_n &  prog_sel_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_EMPTY;
            show_q  <= 1'b0;
            rb_q    <= '0;
        end else begin
            state_q <= state_d;
            show_q  <= show_d;
            rb_q    <= rb_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rb_d    = rb_q;
        show_d  = core_en ? 1'b0 : show_q;
        unique case (state_q)
            SEL_EMPTY: if (hit) begin
                rb_d    = empty_ofs;
                show_d  = 1'b1;
                state_d = sel_step(state_q);
            end
            SEL_FULL: if (hit) begin
                rb_d    = full_ofs;
                show_d  = 1'b1;
                state_d = sel_step(state_q);
            end
        endcase
    end

    assign dout = show_q ? {{PADW{1'b0}}, rb_q} : core_q;
endmodule

// File: rtl/ofs_seq_top.sv
module ofs_seq_top #(
    parameter int DW      = 18,
    parameter int OW      = 14,
    parameter int DEF_OFS = 127
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          prog_sel_n,
    input  logic          wr_req_n,
    input  logic          rd_req_n,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] core_q,
    output logic          core_wr_en,
    output logic          core_rd_en,
    output logic [DW-1:0] core_din,
    output logic [DW-1:0] dout,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    assign core_din = din;

    ofs_wr_seq #(.OW(OW), .DEF_OFS(DEF_OFS)) u_wr (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .prog_sel_n (prog_sel_n),
        .req_n      (wr_req_n),
        .wdata      (din[OW-1:0]),
        .core_en    (core_wr_en),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs)
    );

    ofs_rd_seq #(.DW(DW), .OW(OW)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rst_n),
        .prog_sel_n (prog_sel_n),
        .req_n      (rd_req_n),
        .empty_ofs  (empty_ofs),
        .full_ofs   (full_ofs),
        .core_q     (core_q),
        .core_en    (core_rd_en),
        .dout       (dout)
    );
endmodule

// File: rtl/ofs_seq_chk.sv
module ofs_seq_chk #(
    parameter int DW = 18,
    parameter int OW = 14
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          prog_sel_n,
    input logic          wr_req_n,
    input logic          rd_req_n,
    input logic          core_wr_en,
    input logic          core_rd_en,
    input logic [DW-1:0] dout,
    input logic [OW-1:0] empty_ofs,
    input logic [OW-1:0] full_ofs
);
    a_r4_idle_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_req_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r2_one_reg_per_edge: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!prog_sel_n && !wr_req_n) |=> ($stable(empty_ofs) || $stable(full_ofs)));

    a_r5_no_core_write_in_prog: assert property (@(posedge wr_clk) disable iff (!rst_n)
        core_wr_en |-> (prog_sel_n && !wr_req_n));

    a_r5_normal_write_keeps_regs: assert property (@(posedge wr_clk) disable iff (!rst_n)
        core_wr_en |=> ($stable(empty_ofs) && $stable(full_ofs)));

    a_r6_no_core_read_in_prog: assert property (@(posedge rd_clk) disable iff (!rst_n)
        core_rd_en |-> (prog_sel_n && !rd_req_n));

    a_r7_upper_bits_zero: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!prog_sel_n && !rd_req_n) |=> (dout[DW-1:OW] == '0));
endmodule

bind ofs_seq_top ofs_seq_chk #(.DW(DW), .OW(OW)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .rst_n      (rst_n),
    .prog_sel_n (prog_sel_n),
    .wr_req_n   (wr_req_n),
    .rd_req_n   (rd_req_n),
    .core_wr_en (core_wr_en),
    .core_rd_en (core_rd_en),
    .dout       (dout),
    .empty_ofs  (empty_ofs),
    .full_ofs   (full_ofs)
);

// File: tb/tb_ofs_seq_top.sv
module tb_ofs_seq_top;
    localparam int DW = 18;
    localparam int OW = 14;
    localparam int DEF = 127;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic prog_sel_n = 1'b1, wr_req_n = 1'b1, rd_req_n = 1'b1;
    logic [DW-1:0] din = '0, core_q = 18'h2A5A5;
    logic core_wr_en, core_rd_en;
    logic [DW-1:0] core_din, dout;
    logic [OW-1:0] empty_ofs, full_ofs;

    int n_chk = 0, n_fail = 0;

    // expected model
    logic [OW-1:0] m_e, m_f, m_rb;
    logic m_wp, m_rp, m_show;

    ofs_seq_top #(.DW(DW), .OW(OW), .DEF_OFS(DEF)) dut (.*);

    always #5 begin
        wr_clk = ~wr_clk;
        rd_clk = ~rd_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_dout();
        return m_show ? {{(DW-OW){1'b0}}, m_rb} : core_q;
    endfunction

    task automatic check_state(input string req);
        chk({req, " empty_ofs"}, 32'(empty_ofs), 32'(m_e));
        chk({req, " full_ofs"},  32'(full_ofs),  32'(m_f));
        chk({req, " dout"},      32'(dout),      32'(exp_dout()));
    endtask

    // one cycle: drive at negedge, check gated strobes, clock, update model
    task automatic step(input logic sel, input logic wr, input logic rd, input logic [DW-1:0] d);
        logic [OW-1:0] pe, pf;
        prog_sel_n = sel; wr_req_n = wr; rd_req_n = rd; din = d;
        #1;
        chk("R5 core_wr_en", 32'(core_wr_en), 32'(!wr && sel));
        chk("R6 core_rd_en", 32'(core_rd_en), 32'(!rd && sel));
        @(posedge wr_clk);
        pe = m_e; pf = m_f;
        if (!sel && !wr) begin
            if (m_wp == 1'b0) m_e = d[OW-1:0]; else m_f = d[OW-1:0];
            m_wp = ~m_wp;
        end
        if (!rd) begin
            if (!sel) begin
                m_rb = (m_rp == 1'b0) ? pe : pf;
                m_show = 1'b1;
                m_rp = ~m_rp;
            end else m_show = 1'b0;
        end
        @(negedge wr_clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        prog_sel_n = 1'b1; wr_req_n = 1'b1; rd_req_n = 1'b1;
        m_e = OW'(DEF); m_f = OW'(DEF); m_rb = '0;
        m_wp = 1'b0; m_rp = 1'b0; m_show = 1'b0;
        repeat (2) @(negedge wr_clk);
        rst_n = 1'b1;
        @(negedge wr_clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        check_state("R1 reset");

        // R2/R3: load sweep with upper din bits set
        for (int i = 0; i < 12; i++) begin
            step(1'b0, 1'b0, 1'b1, 18'h3C000 | DW'((i * 1237 + 5) % 16384));
            check_state("R2 R3 load sweep");
        end

        // R4: idle edges at both select levels
        for (int s = 0; s < 2; s++) begin
            step(s[0], 1'b1, 1'b1, 18'h01234);
            check_state("R4 idle");
        end

        // R5: normal writes leave thresholds alone
        step(1'b1, 1'b0, 1'b1, 18'h00777);
        check_state("R5 normal write");

        // R7/R8: read-back sweep, write selector untouched
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b0, '0);
            check_state("R7 readback");
            chk("R7 upper zero", 32'(dout[DW-1:OW]), 32'd0);
        end
        step(1'b0, 1'b1, 1'b1, '0);
        check_state("R10 idle read holds dout");
        step(1'b0, 1'b0, 1'b1, 18'h00111);
        check_state("R8 write selector independent");

        // R10: normal read returns core data
        step(1'b1, 1'b1, 1'b0, '0);
        check_state("R10 normal read");
        core_q = 18'h1F00F;
        #1;
        chk("R10 dout follows core_q", 32'(dout), 32'h1F00F);

        // R11: load and read-back of same register on one edge
        do_reset();
        step(1'b0, 1'b0, 1'b0, 18'h02345);
        check_state("R11 concurrent load/readback");
        chk("R11 readback is old value", 32'(dout), 32'(DEF));
        step(1'b0, 1'b0, 1'b0, 18'h00ABC);
        check_state("R11 both selectors at full");

        // R9: stop after one, normal write, resume at full
        do_reset();
        step(1'b0, 1'b0, 1'b1, 18'h00055);
        step(1'b1, 1'b0, 1'b1, 18'h00999);
        step(1'b0, 1'b0, 1'b1, 18'h00066);
        check_state("R9 resume at full");
        chk("R9 full loaded", 32'(full_ofs), 32'h66);

        // R1: reset mid-sequence restores selectors
        step(1'b0, 1'b0, 1'b1, 18'h00070);
        do_reset();
        check_state("R1 reset restores");
        step(1'b0, 1'b0, 1'b1, 18'h00042);
        chk("R1 selector back to empty", 32'(empty_ofs), 32'h42);
        step(1'b0, 1'b1, 1'b0, '0);
        chk("R1 read selector at empty", 32'(dout), 32'h42);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule